// File: doc/BRIEF.md
# Allocate-on-Write Sparse Page Memory

This block is a memory slave that answers for a wide address window while holding real storage for only a few pages. Each request address is split into a page number and an offset within the page. A small fully associative table records which page number owns each physical frame. A page gets a frame only the first time it receives a nonzero write, and only while a byte budget still allows one more page. A page with no frame reads as zero.

The block is meant to back fuzzing or stimulus environments that scatter accesses over a huge space but touch few pages. Frames are handed out in ascending order, and only reset returns them. Page size, frame count and the byte budget are parameters.

The port is a single synchronous request interface. Each request carries an address, a write enable, a 64-bit write word and a one-hot size code. The read result appears on `rdata_o` one cycle after the request. An error strobe rises in the same cycle when a request is malformed.

Top module: `sparse_page_mem`

## Requirements
- R1: The page number is `addr_i / PAGE_BYTES` and the offset is `addr_i % PAGE_BYTES` (default page 4096 bytes). Equal offsets in different pages are independent locations.
- R2: A read of a page that owns no frame returns all zeros and changes no state.
- R3: A write whose size-masked data is nonzero, sent to a page with no frame, claims the next free frame in ascending order. That frame starts zero-filled, so unwritten bytes of the page read as zero.
- R4: A write of zero to a page with no frame is dropped. It consumes no frame and no budget.
- R5: A frame may be claimed only while (frames in use + 1) * `PAGE_BYTES` is strictly below `MAX_BYTES`, and only while a free frame remains. Otherwise the write to the unmapped page is discarded.
- R6: Once a page owns a frame, every later write to it updates the frame, including writes of zero.
- R7: `size_i` is one-hot: 4'b0001 = 1 byte, 4'b0010 = 2, 4'b0100 = 4, 4'b1000 = 8. Data is little-endian, with the lowest address in bits [7:0]. Read data is right-justified with the bytes above the size zeroed. Write data bits above the size are ignored.
- R8: Any other `size_i` value, or an address that is not a multiple of the size, makes `err_o` high in the cycle after the request. Such a request changes no state and returns zero on `rdata_o`.
- R9: Reset removes all mappings, clears the frame count and restores the full budget. Afterwards every page reads zero.
- R10: `rdata_o` is updated one cycle after each request. It carries the read value for a good read and zero for writes. It holds while `req_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 64 | Write data, right-justified |
| size_i | input | 4 | One-hot access size code |
| rdata_o | output | 64 | Read data, one cycle after the request |
| err_o | output | 1 | Malformed request strobe, one cycle after the request |

## Verification
The bench builds the block with 64-byte pages, three frames and a budget of 192 bytes. Under the strict limit this budget admits only two pages, which leaves one physical frame unused. A third nonzero page write is therefore refused by the byte budget rather than by running out of frames. The small page size lets a 20-bit address reach far-apart pages that share offsets, so a few writes show that pages are independent. The tiny budget also shows that dropped zero writes and reset both leave the allocation capacity intact.

// File: rtl/sparse_page_mem.sv
module sparse_page_mem #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int FRAMES     = 2,
  parameter int MAX_BYTES  = 3 * 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  input  logic [3:0]        size_i,
  output logic [63:0]       rdata_o,
  output logic              err_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PN_W  = ADDR_W - OFF_W;
  localparam int WPP   = PAGE_BYTES / 8;
  localparam int WI_W  = $clog2(WPP);
  localparam int FI_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int CNT_W = $clog2(FRAMES + 1);
  localparam int DEPTH = FRAMES * WPP;
  localparam int SI_W  = $clog2(DEPTH);

  logic [PN_W-1:0]  tag_q [FRAMES];
  logic [FRAMES-1:0] vld_q;
  logic [CNT_W-1:0] used_q;
  logic [63:0]      mem [DEPTH];
  logic [DEPTH-1:0] wv_q;

  logic [PN_W-1:0] pn;
  logic [WI_W-1:0] widx;
  logic [5:0]      sh;
  logic            size_ok, align_ok, bad, hit, room, nz, alloc, do_wr;
  logic [FI_W-1:0] hit_idx, frame;
  logic [SI_W-1:0] sidx;
  logic [63:0]     bmask, lmask, wval, cur, merged, rdval;

  assign pn       = addr_i[ADDR_W-1:OFF_W];
  assign widx     = addr_i[OFF_W-1:3];
  assign sh       = {addr_i[2:0], 3'b000};
  assign size_ok  = (size_i == 4'd1) || (size_i == 4'd2) || (size_i == 4'd4) || (size_i == 4'd8);
  assign align_ok = (addr_i[2:0] & (size_i[2:0] - 3'd1)) == 3'd0;
  assign bad      = req_i && !(size_ok && align_ok);

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < FRAMES; i++)
      if (vld_q[i] && tag_q[i] == pn) begin
        hit     = 1'b1;
        hit_idx = FI_W'(i);
      end
  end

  always_comb
    case (size_i)
      4'd1:    bmask = 64'h0000_0000_0000_00FF;
      4'd2:    bmask = 64'h0000_0000_0000_FFFF;
      4'd4:    bmask = 64'h0000_0000_FFFF_FFFF;
      default: bmask = '1;
    endcase

  assign room   = (used_q < CNT_W'(FRAMES)) &&
                  ((64'(used_q) + 64'd1) * 64'(PAGE_BYTES) < 64'(MAX_BYTES));
  assign wval   = wdata_i & bmask;
  assign nz     = |wval;
  assign alloc  = req_i && we_i && !bad && !hit && nz && room;
  assign do_wr  = req_i && we_i && !bad && (hit || alloc);
  assign frame  = hit ? hit_idx : FI_W'(used_q);
  assign sidx   = SI_W'(int'(frame) * WPP + int'(widx));
  assign cur    = wv_q[sidx] ? mem[sidx] : 64'd0;
  assign lmask  = bmask << sh;
  assign merged = (cur & ~lmask) | ((wval << sh) & lmask);
  assign rdval  = (cur >> sh) & bmask;

  always_ff @(posedge clk_i)
    if (do_wr) mem[sidx] <= merged;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      vld_q   <= '0;
      used_q  <= '0;
      wv_q    <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
      for (int i = 0; i < FRAMES; i++) tag_q[i] <= '0;
    end else begin
      err_o <= bad;
      if (req_i) rdata_o <= (!we_i && !bad && hit) ? rdval : 64'd0;
      if (alloc) begin
        vld_q[frame] <= 1'b1;
        tag_q[frame] <= pn;
        used_q       <= used_q + CNT_W'(1);
      end
      if (do_wr) wv_q[sidx] <= 1'b1;
    end
endmodule

// File: rtl/sparse_page_mem_chk.sv
module sparse_page_mem_chk #(
  parameter int FRAMES = 2,
  parameter int CNT_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [3:0]       size_i,
  input logic [63:0]      rdata_o,
  input logic             err_o,
  input logic [CNT_W-1:0] used_q
);
  // R8
  err_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == 64'd0);
  // R8
  err_no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(used_q));
  // R8
  bad_size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(size_i == 4'd1 || size_i == 4'd2 || size_i == 4'd4 || size_i == 4'd8)) |=> err_o);
  // R5
  used_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(used_q) <= FRAMES);
  // R3
  used_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q == $past(used_q)) || (used_q == $past(used_q) + CNT_W'(1)));
  // R7
  byte_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 4'd1) |=> rdata_o[63:8] == 56'd0);
  // R10
  write_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> rdata_o == 64'd0);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(rdata_o));
endmodule

bind sparse_page_mem sparse_page_mem_chk #(.FRAMES(FRAMES), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .size_i(size_i),
  .rdata_o(rdata_o), .err_o(err_o), .used_q(used_q)
);

// File: tb/test_sparse_page_mem.sv
module test_sparse_page_mem;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [3:0]  size_i = 4'd8;
  logic [63:0] rdata_o;
  logic        err_o;
  int checks = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  sparse_page_mem #(.ADDR_W(20), .PAGE_BYTES(64), .FRAMES(3), .MAX_BYTES(192)) i_sparse_page_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .size_i(size_i), .rdata_o(rdata_o), .err_o(err_o));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [19:0] a, input logic [63:0] d,
                     input logic [3:0] s, output logic [63:0] rd, output logic er);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d; size_i = s;
    @(negedge clk_i);
    rd = rdata_o; er = err_o;
    req_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [19:0] a, input logic [3:0] s,
                        input logic [63:0] exp);
    logic [63:0] rd; logic er;
    acc(1'b0, a, 64'd0, s, rd, er);
    chk(req, rd, exp);
    chk(req, {63'd0, er}, 64'd0);
  endtask

  task automatic wr(input logic [19:0] a, input logic [63:0] d, input logic [3:0] s);
    logic [63:0] rd; logic er;
    acc(1'b1, a, d, s, rd, er);
    chk("R10 write returns zero", rd, 64'd0);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    chk("R9 rdata after reset", rdata_o, 64'd0);
    chk("R9 err after reset", {63'd0, err_o}, 64'd0);
  endtask

  task automatic t_unmapped();
    rd_chk("R2 unmapped read", 20'h00140, 4'd8, 64'd0);
    rd_chk("R2 unmapped far read", 20'hFFFF8, 4'd8, 64'd0);
  endtask

  task automatic t_zero_drop_and_cap();
    wr(20'h04000, 64'd0, 4'd8);
    rd_chk("R4 zero write dropped", 20'h04000, 4'd8, 64'd0);
    wr(20'h00080, 64'h0102030405060708, 4'd8);
    wr(20'h000C0, 64'hCAFE0001, 4'd4);
    rd_chk("R4 R3 first page kept", 20'h00080, 4'd8, 64'h0102030405060708);
    rd_chk("R4 R5 second page kept", 20'h000C0, 4'd4, 64'hCAFE0001);
    wr(20'h00100, 64'h55, 4'd1);
    rd_chk("R5 budget blocks third page", 20'h00100, 4'd1, 64'd0);
  endtask

  task automatic t_mapped_zero();
    wr(20'h00080, 64'd0, 4'd8);
    rd_chk("R6 zero write to mapped page", 20'h00080, 4'd8, 64'd0);
    wr(20'h00088, 64'h1111, 4'd8);
  endtask

  task automatic t_endian();
    wr(20'h000C8, 64'h8877665544332211, 4'd8);
    rd_chk("R7 byte 0", 20'h000C8, 4'd1, 64'h11);
    rd_chk("R7 byte 3", 20'h000CB, 4'd1, 64'h44);
    rd_chk("R7 half", 20'h000CA, 4'd2, 64'h4433);
    rd_chk("R7 word", 20'h000CC, 4'd4, 64'h88776655);
    wr(20'h000C9, 64'hFFFFFFFFFFFFFFAA, 4'd1);
    rd_chk("R7 byte merge", 20'h000C8, 4'd8, 64'h887766554433AA11);
    rd_chk("R3 zero fill", 20'h000D0, 4'd8, 64'd0);
    rd_chk("R1 pages independent", 20'h00088, 4'd8, 64'h1111);
  endtask

  task automatic t_errors();
    logic [63:0] rd; logic er;
    acc(1'b0, 20'h000C8, 64'd0, 4'd3, rd, er);
    chk("R8 bad size err", {63'd0, er}, 64'd1);
    chk("R8 bad size rdata", rd, 64'd0);
    acc(1'b1, 20'h000C9, 64'hBEEF, 4'd2, rd, er);
    chk("R8 misaligned err", {63'd0, er}, 64'd1);
    acc(1'b1, 20'h000CA, 64'hDEADBEEF, 4'd4, rd, er);
    chk("R8 misaligned word err", {63'd0, er}, 64'd1);
    rd_chk("R8 no update", 20'h000C8, 4'd8, 64'h887766554433AA11);
    acc(1'b0, 20'h000C8, 64'd0, 4'd8, rd, er);
    acc(1'b0, 20'h000C0, 64'd0, 4'd0, rd, er);
    chk("R8 size zero err", {63'd0, er}, 64'd1);
    chk("R8 err read zero", rd, 64'd0);
  endtask

  task automatic t_reset_clear();
    do_reset();
    rd_chk("R9 mapping cleared", 20'h000C8, 4'd8, 64'd0);
    wr(20'h00100, 64'h77, 4'd1);
    wr(20'h00140, 64'h99, 4'd1);
    rd_chk("R9 budget restored a", 20'h00100, 4'd1, 64'h77);
    rd_chk("R9 budget restored b", 20'h00140, 4'd1, 64'h99);
    wr(20'h00180, 64'h33, 4'd1);
    rd_chk("R5 limit after reset", 20'h00180, 4'd1, 64'd0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_unmapped();
    t_zero_drop_and_cap();
    t_mapped_zero();
    t_endian();
    t_errors();
    t_reset_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule